// File: doc/BRIEF.md
# Scan Access Guard Controller

This controller sits between the test access pins and the scan chain of a cipher core. It decides whether the core is in mission mode or test mode. In mission mode the scan enable that reaches the chain is held low, and the core runs on its own secret key.

When a test request arrives, the controller does three things before it allows any shift. It pulses a reset into the core's functional flip-flops. It switches the core's key multiplexer to a fixed test key. It then checks a multi-bit pattern from reset-sensitive flip-flops, which confirms that the reset really cleared the core. Leaving test mode works the same way: a reset pulse, then the same check.

A failed check raises an alarm. The alarm holds until power-on reset, and while it is set the controller stays in mission mode and ignores further test requests.

Top module: `scan_guard`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises with test_req_i low, scan_en_o, key_sel_o, core_rst_o and alarm_o are all 0.
- R2: In mission mode scan_en_o is 0 whatever scan_en_i does.
- R3: In mission mode without alarm, test_req_i at 1 on a clock edge starts an entry sequence with core_rst_o at 1 for exactly RST_CYCLES cycles (default 4) beginning the next cycle. key_sel_o is 1 (test key) from the first of these cycles.
- R4: scan_en_o stays 0 during every reset pulse and during the check cycle that follows it.
- R5: The check cycle is the one cycle right after the entry pulse, with key_sel_o=1 and core_rst_o=0. If flag_i equals FLAG_PATTERN (default 8'hA5) at the edge that ends that cycle, the controller enters test mode.
- R6: Any other flag_i value at the entry check, including a single flipped bit, sets alarm_o from the next cycle and returns to mission mode with key_sel_o=0.
- R7: alarm_o, once set, stays 1 until rst_ni goes low. While it is set, test_req_i has no effect: scan_en_o, key_sel_o and core_rst_o stay 0.
- R8: In test mode key_sel_o is 1 and scan_en_o equals scan_en_i in the same cycle.
- R9: test_req_i at 0 in test mode starts an exit sequence. core_rst_o is 1 for RST_CYCLES cycles with key_sel_o=0, followed by one check cycle. A match then gives mission mode without alarm; a mismatch gives mission mode with alarm_o set.
- R10: Dropping test_req_i during an entry sequence does not abort it. The entry completes into test mode for one cycle, and the exit sequence starts after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| test_req_i | input | 1 | Request for test mode (1) or mission mode (0) |
| scan_en_i | input | 1 | Raw scan enable from the test pins |
| flag_i | input | FLAG_W | Reset-check vector from reset-sensitive flip-flops |
| scan_en_o | output | 1 | Gated scan enable to the chain |
| key_sel_o | output | 1 | Key multiplexer select, 1 picks the fixed test key |
| core_rst_o | output | 1 | Reset pulse for the core's functional flip-flops |
| alarm_o | output | 1 | Sticky reset-check failure |

## Verification
The main sequence is driven with a matching flag, a flag with one bit flipped, and an all-zero or all-one flag, at both the entry and the exit check. This shows that the comparison covers every bit and is made in the right cycle. Raw scan enable is toggled in mission, reset, check and test cycles, which shows that only the test state lets it through. Test requests issued after an alarm, and a request dropped in the middle of entry, show that the alarm locks the controller and that a half-finished entry cannot skip its reset.

// File: rtl/scan_guard_pkg.sv
package scan_guard_pkg;
  typedef enum logic [2:0] {
    ST_MISSION   = 3'd0,
    ST_ENTER_RST = 3'd1,
    ST_ENTER_CHK = 3'd2,
    ST_TEST      = 3'd3,
    ST_EXIT_RST  = 3'd4,
    ST_EXIT_CHK  = 3'd5
  } mode_e;
endpackage

// File: rtl/scan_guard_timer.sv
module scan_guard_timer #(
  parameter int RST_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(RST_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + CW'(1);
  end

  assign done_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/scan_guard_flagchk.sv
module scan_guard_flagchk #(
  parameter int              FLAG_W       = 8,
  parameter logic [FLAG_W-1:0] FLAG_PATTERN = 8'hA5
) (
  input  logic [FLAG_W-1:0] flag_i,
  output logic              ok_o
);
  logic [FLAG_W-1:0] miss;

  for (genvar b = 0; b < FLAG_W; b++) begin : g_bit
    assign miss[b] = flag_i[b] ^ FLAG_PATTERN[b];
  end

  assign ok_o = ~|miss;
endmodule

// File: rtl/scan_guard_fsm.sv
module scan_guard_fsm
  import scan_guard_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  test_req_i,
  input  logic  rst_done_i,
  input  logic  flag_ok_i,
  output mode_e state_o,
  output logic  alarm_o
);
  mode_e state_q, state_d;
  logic  alarm_q, alarm_d;

  always_comb begin
    state_d = state_q;
    alarm_d = alarm_q;
    unique case (state_q)
      ST_MISSION:   if (test_req_i && !alarm_q) state_d = ST_ENTER_RST;
      ST_ENTER_RST: if (rst_done_i) state_d = ST_ENTER_CHK;
      ST_ENTER_CHK: begin
        if (flag_ok_i) state_d = ST_TEST;
        else begin
          state_d = ST_MISSION;
          alarm_d = 1'b1;
        end
      end
      ST_TEST:      if (!test_req_i) state_d = ST_EXIT_RST;
      ST_EXIT_RST:  if (rst_done_i) state_d = ST_EXIT_CHK;
      ST_EXIT_CHK: begin
        state_d = ST_MISSION;
        if (!flag_ok_i) alarm_d = 1'b1;
      end
      default:      state_d = ST_MISSION;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_MISSION;
      alarm_q <= 1'b0;
    end else begin
      state_q <= state_d;
      alarm_q <= alarm_d;
    end
  end

  assign state_o = state_q;
  assign alarm_o = alarm_q;
endmodule

// File: rtl/scan_guard.sv
module scan_guard
  import scan_guard_pkg::*;
#(
  parameter int                FLAG_W       = 8,
  parameter logic [FLAG_W-1:0] FLAG_PATTERN = 8'hA5,
  parameter int                RST_CYCLES   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              test_req_i,
  input  logic              scan_en_i,
  input  logic [FLAG_W-1:0] flag_i,
  output logic              scan_en_o,
  output logic              key_sel_o,
  output logic              core_rst_o,
  output logic              alarm_o
);
  mode_e state;
  logic  in_rst, rst_done, flag_ok;

  assign in_rst = (state == ST_ENTER_RST) || (state == ST_EXIT_RST);

  scan_guard_timer #(.RST_CYCLES(RST_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (in_rst),
    .done_o (rst_done)
  );

  scan_guard_flagchk #(.FLAG_W(FLAG_W), .FLAG_PATTERN(FLAG_PATTERN)) u_flagchk (
    .flag_i (flag_i),
    .ok_o   (flag_ok)
  );

  scan_guard_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .test_req_i (test_req_i),
    .rst_done_i (rst_done),
    .flag_ok_i  (flag_ok),
    .state_o    (state),
    .alarm_o    (alarm_o)
  );

  // test key is selected from the start of the entry pulse so the core
  // leaves reset already holding the non-secret key
  assign key_sel_o  = (state == ST_ENTER_RST) || (state == ST_ENTER_CHK) ||
                      (state == ST_TEST);
  assign core_rst_o = in_rst;
  assign scan_en_o  = (state == ST_TEST) && scan_en_i;
endmodule

// File: rtl/scan_guard_chk.sv
module scan_guard_chk #(
  parameter int RST_CYCLES = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic scan_en_i,
  input logic scan_en_o,
  input logic key_sel_o,
  input logic core_rst_o,
  input logic alarm_o
);
  localparam int RW = $clog2(RST_CYCLES + 2) + 1;
  logic [RW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         run_q <= '0;
    else if (core_rst_o) run_q <= run_q + RW'(1);
    else                 run_q <= '0;
  end

  p_mission_scan_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !key_sel_o |-> !scan_en_o);

  p_rst_pulse_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!core_rst_o && run_q != '0) |-> (run_q == RW'(RST_CYCLES)));

  p_rst_pulse_max_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= RW'(RST_CYCLES));

  p_no_scan_in_rst_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_rst_o |-> !scan_en_o);

  p_alarm_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_o |=> alarm_o);

  p_alarm_locked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_o |-> (!scan_en_o && !key_sel_o && !core_rst_o));

  p_scan_follows_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_en_o |-> (scan_en_i && key_sel_o));
endmodule

bind scan_guard scan_guard_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scan_en_i  (scan_en_i),
  .scan_en_o  (scan_en_o),
  .key_sel_o  (key_sel_o),
  .core_rst_o (core_rst_o),
  .alarm_o    (alarm_o)
);

// File: tb/scan_guard_tb.sv
module scan_guard_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       test_req_i = 1'b0;
  logic       scan_en_i = 1'b0;
  logic [7:0] flag_i = 8'h00;
  logic       scan_en_o, key_sel_o, core_rst_o, alarm_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  scan_guard u_dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .test_req_i (test_req_i),
    .scan_en_i  (scan_en_i),
    .flag_i     (flag_i),
    .scan_en_o  (scan_en_o),
    .key_sel_o  (key_sel_o),
    .core_rst_o (core_rst_o),
    .alarm_o    (alarm_o)
  );

  // row: {req, scan_en, flag[7:0], exp scan_en_o, key_sel_o, core_rst_o, alarm_o}
  localparam logic [13:0] VEC [23] = '{
    {1'b0, 1'b1, 8'h00, 4'b0000},  //  0 R2 mission
    {1'b1, 1'b1, 8'hA5, 4'b0110},  //  1 R3 R4 entry pulse
    {1'b1, 1'b1, 8'hA5, 4'b0110},  //  2
    {1'b1, 1'b1, 8'hA5, 4'b0110},  //  3
    {1'b1, 1'b1, 8'hA5, 4'b0110},  //  4
    {1'b1, 1'b1, 8'hA5, 4'b0100},  //  5 R5 check cycle
    {1'b1, 1'b1, 8'hA5, 4'b1100},  //  6 R5 R8 test mode
    {1'b1, 1'b0, 8'hA5, 4'b0100},  //  7 R8
    {1'b0, 1'b1, 8'hA5, 4'b0010},  //  8 R9 exit pulse
    {1'b0, 1'b1, 8'hA5, 4'b0010},  //  9
    {1'b0, 1'b1, 8'hA5, 4'b0010},  // 10
    {1'b0, 1'b1, 8'hA5, 4'b0010},  // 11
    {1'b0, 1'b1, 8'hA5, 4'b0000},  // 12 R9 exit check
    {1'b0, 1'b1, 8'hA5, 4'b0000},  // 13 R9 clean return
    {1'b1, 1'b1, 8'h00, 4'b0110},  // 14 R3 second entry
    {1'b1, 1'b1, 8'h00, 4'b0110},  // 15
    {1'b1, 1'b1, 8'h00, 4'b0110},  // 16
    {1'b1, 1'b1, 8'h00, 4'b0110},  // 17
    {1'b1, 1'b1, 8'h00, 4'b0100},  // 18
    {1'b1, 1'b1, 8'hA4, 4'b0001},  // 19 R6 one bit off
    {1'b1, 1'b1, 8'hA5, 4'b0001},  // 20 R7
    {1'b0, 1'b1, 8'hA5, 4'b0001},  // 21 R7
    {1'b1, 1'b1, 8'hA5, 4'b0001}   // 22 R7
  };

  function automatic string vec_req(int i);
    if (i == 0)  return "R2";
    if (i <= 4)  return "R3";
    if (i == 5)  return "R5";
    if (i <= 7)  return "R8";
    if (i <= 13) return "R9";
    if (i <= 18) return "R3";
    if (i == 19) return "R6";
    return "R7";
  endfunction

  task automatic check(string req, logic [3:0] exp);
    logic [3:0] act;
    act = {scan_en_o, key_sel_o, core_rst_o, alarm_o};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%b exp=%b (scan,key,rst,alarm) t=%0t", req, act, exp, $time);
    end
  endtask

  // apply at a falling edge, check at the next falling edge
  task automatic step(logic req, logic sen, logic [7:0] flg, logic [3:0] exp, string tag);
    test_req_i = req;
    scan_en_i  = sen;
    flag_i     = flg;
    @(negedge clk_i);
    check(tag, exp);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    test_req_i = 1'b1;
    scan_en_i  = 1'b1;
    @(negedge clk_i);
    check("R1", 4'b0000);
    rst_ni = 1'b1;
  endtask

  initial begin
    @(negedge clk_i);
    do_reset();
    step(1'b0, 1'b1, 8'h00, 4'b0000, "R1");

    for (int i = 0; i < 23; i++)
      step(VEC[i][13], VEC[i][12], VEC[i][11:4], VEC[i][3:0], vec_req(i));

    // R7: only power-on reset clears the alarm
    do_reset();
    step(1'b0, 1'b0, 8'h00, 4'b0000, "R7");

    // R10: request drops right after entry starts
    step(1'b1, 1'b1, 8'h00, 4'b0110, "R10");
    for (int k = 0; k < 3; k++) step(1'b0, 1'b1, 8'h00, 4'b0110, "R10");
    step(1'b0, 1'b1, 8'h00, 4'b0100, "R10");
    step(1'b0, 1'b1, 8'hA5, 4'b1100, "R10");
    for (int k = 0; k < 4; k++) step(1'b0, 1'b1, 8'hA5, 4'b0010, "R9");
    step(1'b0, 1'b1, 8'hA5, 4'b0000, "R9");
    // R9: failed exit check raises alarm
    step(1'b0, 1'b1, 8'hFF, 4'b0001, "R9");
    step(1'b1, 1'b1, 8'hA5, 4'b0001, "R7");

    // R6: all-zero flag at entry check
    do_reset();
    step(1'b1, 1'b1, 8'h00, 4'b0110, "R3");
    for (int k = 0; k < 3; k++) step(1'b1, 1'b0, 8'h00, 4'b0110, "R4");
    step(1'b1, 1'b1, 8'h00, 4'b0100, "R4");
    step(1'b1, 1'b1, 8'h00, 4'b0001, "R6");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule